// File: doc/BRIEF.md
# Muller C-Element Pipeline and Ring Model

This block is a cycle-stepped, synthesizable model of a chain of Muller C-elements. Each stage is a single state bit that behaves as a C-element. Its two inputs are the value of the stage before it and the inverted value of the stage after it. On every clock edge all stages are evaluated together, each from the values the whole chain held before that edge. Transitions therefore travel along the chain as waves, one stage per step, and never race ahead.

A parameter selects how the two ends are wired. In open mode the chain is a pipeline control path. The requester drives the head input, and the head stage is echoed back to it as the left acknowledge. The tail stage is presented as the right request, and the consumer returns an acknowledge that feeds the tail's inverted successor input. In ring mode the tail feeds the head, the head closes the tail's feedback, and the external handshake pins are not used. A parameter vector loaded at reset gives the starting pattern of tokens and bubbles.

A counter advances each time the tail stage changes value. It measures how often waves or tokens leave the chain, or how often they pass the tail in a ring.

Top module: `cring_top`

## Requirements
- R1: While `rst` is high at a clock edge, the stages load `INIT_PATTERN`, with bit i belonging to stage i and stage 0 at the head, and `toggles_o` is cleared to zero.
- R2: At each step, a stage whose predecessor value differs from its successor value takes the predecessor value. If those two values are equal, the stage keeps its own value.
- R3: All stages update on the same edge, and each uses only values from before that edge. One step moves a wave forward by at most one stage.
- R4: In open mode (`RING_MODE` = 0), the predecessor of stage 0 is `req_i`, and `left_ack_o` equals stage 0.
- R5: In open mode, the successor value of the last stage is `ack_i`, and `right_req_o` equals the last stage. Raising `ack_i` lets a pending tail value drain.
- R6: In open mode with `ack_i` held low, a 4-stage chain fed with two full request cycles ends holding the alternating pattern `stages_o` = 4'b1010. Further toggling of `req_i` leaves it unchanged.
- R7: In ring mode (`RING_MODE` = 1), the predecessor of stage 0 is the last stage, and the successor of the last stage is stage 0. `req_i` and `ack_i` have no effect.
- R8: A 3-stage ring started from `INIT_PATTERN` = 3'b100 changes exactly one stage per step. It steps through 100, 101, 001, 011, 010, 110 and then repeats with period 6. Its last stage changes once every 3 steps.
- R9: `toggles_o` increases by one, modulo 2^`CNT_W`, on each step in which the last stage changes value, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; every rising edge is one evaluation step |
| rst | input | 1 | Synchronous active-high reset; loads the start pattern |
| req_i | input | 1 | Left request, the head stage's predecessor in open mode |
| ack_i | input | 1 | Right acknowledge, the tail stage's successor value in open mode |
| stages_o | output | N_STAGES | Current value of every stage, bit i = stage i |
| left_ack_o | output | 1 | Head stage value, returned to the requester |
| right_req_o | output | 1 | Tail stage value, offered to the consumer |
| toggles_o | output | CNT_W | Count of tail-stage transitions, wrapping |

## Verification
A 4-stage open pipeline first receives directed request waves with the acknowledge held low. These show that waves travel one stage per step, that the chain fills, that it then stalls on the alternating pattern, and that extra request toggles are ignored. A single acknowledge then shows that the tail drains. A long sweep then drives request and acknowledge through many mixed patterns, and every step is compared against an arithmetic C-element model of the stage values and the tail counter. The same sweep drives a 3-stage ring alongside, and its state is matched against the six-state token cycle. This shows that the handshake pins are ignored in ring mode, that one stage moves per step, and that the tail counter wraps at the right step.

// File: rtl/cring_pkg.sv
package cring_pkg;

  // Next value of a C-element holding q, with inputs a and b.
  function automatic logic celem_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

endpackage

// File: rtl/cring_celem.sv
module cring_celem #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  import cring_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) q_o <= INIT_VAL;
    else     q_o <= celem_next(a_i, b_i, q_o);
  end
endmodule

// File: rtl/cring_ends.sv
module cring_ends #(
  parameter bit RING_MODE = 1'b0
) (
  input  logic req_i,
  input  logic ack_i,
  input  logic first_i,
  input  logic last_i,
  output logic head_a_o,
  output logic tail_b_o
);
  generate
    if (RING_MODE) begin : g_ring
      logic unused_pins;
      assign unused_pins = req_i ^ ack_i;
      assign head_a_o = last_i;
      assign tail_b_o = ~first_i;
    end else begin : g_open
      logic unused_taps;
      assign unused_taps = first_i ^ last_i;
      assign head_a_o = req_i;
      assign tail_b_o = ~ack_i;
    end
  endgenerate
endmodule

// File: rtl/cring_tcount.sv
module cring_tcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cring_top.sv
module cring_top #(
  parameter int                  N_STAGES     = 4,
  parameter bit                  RING_MODE    = 1'b0,
  parameter logic [N_STAGES-1:0] INIT_PATTERN = '0,
  parameter int                  CNT_W        = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic                ack_i,
  output logic [N_STAGES-1:0] stages_o,
  output logic                left_ack_o,
  output logic                right_req_o,
  output logic [CNT_W-1:0]    toggles_o
);
  localparam int LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] st;
  logic [N_STAGES-1:0] pred;
  logic [N_STAGES-1:0] succ_inv;
  logic                head_a;
  logic                tail_b;
  logic                tail_tick;

  cring_ends #(.RING_MODE(RING_MODE)) ends_i (
    .req_i    (req_i),
    .ack_i    (ack_i),
    .first_i  (st[0]),
    .last_i   (st[LAST]),
    .head_a_o (head_a),
    .tail_b_o (tail_b)
  );

  generate
    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign pred[i] = head_a;
      end else begin : g_pred
        assign pred[i] = st[i-1];
      end
      if (i == LAST) begin : g_tail
        assign succ_inv[i] = tail_b;
      end else begin : g_succ
        assign succ_inv[i] = ~st[i+1];
      end
      cring_celem #(.INIT_VAL(INIT_PATTERN[i])) cel_i (
        .clk (clk),
        .rst (rst),
        .a_i (pred[i]),
        .b_i (succ_inv[i]),
        .q_o (st[i])
      );
    end
  endgenerate

  // Tail will change on this edge: inputs agree and differ from current value.
  assign tail_tick = (pred[LAST] == succ_inv[LAST]) && (pred[LAST] != st[LAST]);

  cring_tcount #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tail_tick),
    .cnt_o  (toggles_o)
  );

  assign stages_o    = st;
  assign left_ack_o  = st[0];
  assign right_req_o = st[LAST];
endmodule

// File: rtl/cring_chk.sv
module cring_chk #(
  parameter int                  N_STAGES     = 4,
  parameter bit                  RING_MODE    = 1'b0,
  parameter logic [N_STAGES-1:0] INIT_PATTERN = '0,
  parameter int                  CNT_W        = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                req_i,
  input logic                ack_i,
  input logic [N_STAGES-1:0] st,
  input logic [CNT_W-1:0]    cnt
);
  localparam int LAST = N_STAGES - 1;

  logic armed;
  logic head_v;
  logic tail_v;

  always_ff @(posedge clk) armed <= !rst;

  generate
    if (RING_MODE) begin : g_ring
      logic unused_pins;
      assign unused_pins = req_i ^ ack_i;
      assign head_v = st[LAST];
      assign tail_v = st[0];
    end else begin : g_open
      assign head_v = req_i;
      assign tail_v = ack_i;
    end
  endgenerate

  // R1: reset loads the start pattern and clears the counter
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (st == INIT_PATTERN && cnt == '0));

  generate
    for (genvar i = 1; i < LAST; i++) begin : g_mid
      // R2, R3: a middle stage moves only to its old predecessor value
      a_r2_mid_move: assert property (@(posedge clk) disable iff (rst || !armed)
        !$stable(st[i]) |-> (st[i] == $past(st[i-1]) && st[i] != $past(st[i+1])));
      // R2: differing neighbours force the copy
      a_r2_mid_copy: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(st[i-1]) != $past(st[i+1])) |-> st[i] == $past(st[i-1]));
    end
  endgenerate

  // R4 (R7 in ring mode): head moves only toward its predecessor
  a_r4_head: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(st[0]) |-> (st[0] == $past(head_v) && st[0] != $past(st[1])));

  // R5 (R7 in ring mode): tail moves only when its successor disagrees
  a_r5_tail: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(st[LAST]) |-> (st[LAST] == $past(st[LAST-1]) && st[LAST] != $past(tail_v)));

  // R9: counter steps by one on a tail change
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(st[LAST]) |-> cnt == $past(cnt) + 1'b1);

  // R9: counter holds when the tail holds
  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    $stable(st[LAST]) |-> $stable(cnt));
endmodule

bind cring_top cring_chk #(
  .N_STAGES     (N_STAGES),
  .RING_MODE    (RING_MODE),
  .INIT_PATTERN (INIT_PATTERN),
  .CNT_W        (CNT_W)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .req_i (req_i),
  .ack_i (ack_i),
  .st    (stages_o),
  .cnt   (toggles_o)
);

// File: tb/cring_top_tb_top.sv
module cring_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] o_st;
  logic       o_la, o_rr;
  logic [3:0] o_cnt;
  logic [2:0] r_st;
  logic       r_la, r_rr;
  logic [3:0] r_cnt;

  cring_top #(.N_STAGES(4), .RING_MODE(1'b0), .INIT_PATTERN(4'b0000), .CNT_W(4)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack),
    .stages_o(o_st), .left_ack_o(o_la), .right_req_o(o_rr), .toggles_o(o_cnt)
  );

  cring_top #(.N_STAGES(3), .RING_MODE(1'b1), .INIT_PATTERN(3'b100), .CNT_W(4)) dut_ring_i (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack),
    .stages_o(r_st), .left_ack_o(r_la), .right_req_o(r_rr), .toggles_o(r_cnt)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] m_st  = 4'b0000;
  logic [3:0] m_cnt = 4'd0;
  int         ring_n = 0;

  function automatic logic [2:0] ring_expect(input int n);
    case (n % 6)
      0:       return 3'b100;
      1:       return 3'b101;
      2:       return 3'b001;
      3:       return 3'b011;
      4:       return 3'b010;
      default: return 3'b110;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic ak);
    logic [3:0] nx;
    logic [2:0] r_prev;
    req = rq;
    ack = ak;
    r_prev = r_st;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      logic p, s;
      p = (i == 0) ? rq : m_st[i-1];
      s = (i == 3) ? ak : m_st[i+1];
      nx[i] = (p != s) ? p : m_st[i];
    end
    if (nx[3] != m_st[3]) m_cnt = m_cnt + 4'd1;
    m_st = nx;
    ring_n++;
    @(negedge clk);
    check(o_st == m_st, "R2 R3 open stages", o_st, m_st);
    check(o_cnt == m_cnt, "R9 open tail count", o_cnt, m_cnt);
    check(o_la == m_st[0], "R4 left ack", o_la, m_st[0]);
    check(o_rr == m_st[3], "R5 right req", o_rr, m_st[3]);
    check(r_st == ring_expect(ring_n), "R7 R8 ring state", r_st, ring_expect(ring_n));
    check($countones(r_st ^ r_prev) == 1, "R8 one stage per step", $countones(r_st ^ r_prev), 1);
    check(r_cnt == 4'((ring_n + 1) / 3), "R9 ring tail count", r_cnt, 4'((ring_n + 1) / 3));
    if (ring_n == 47)
      check(r_cnt == 4'd0, "R9 counter wrap", r_cnt, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 R9 run hung actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(o_st == 4'b0000, "R1 open reset stages", o_st, 0);
    check(o_cnt == 4'd0, "R1 open reset count", o_cnt, 0);
    check(r_st == 3'b100, "R1 ring reset stages", r_st, 3'b100);
    check(r_cnt == 4'd0, "R1 ring reset count", r_cnt, 0);
    rst = 1'b0;

    // Waves with acknowledge held low.
    step(1'b1, 1'b0);
    check(o_st == 4'b0001, "R4 head takes request", o_st, 4'b0001);
    repeat (3) step(1'b1, 1'b0);
    check(o_st == 4'b1111, "R3 R5 wave reaches tail", o_st, 4'b1111);
    repeat (4) step(1'b0, 1'b0);
    check(o_st == 4'b1000, "R3 second wave", o_st, 4'b1000);
    repeat (4) step(1'b1, 1'b0);
    check(o_st == 4'b1011, "R6 filling", o_st, 4'b1011);
    repeat (4) step(1'b0, 1'b0);
    check(o_st == 4'b1010, "R6 full pattern", o_st, 4'b1010);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    check(o_st == 4'b1010, "R6 stalled request ignored", o_st, 4'b1010);

    // Acknowledge drains the tail.
    step(1'b0, 1'b1);
    check(o_st == 4'b0010, "R5 acknowledge drains tail", o_st, 4'b0010);

    // Mixed sweep of request and acknowledge patterns.
    for (int k = 0; k < 320; k++) begin
      logic [8:0] kv;
      kv = 9'(k);
      step(kv[0] ^ kv[3] ^ kv[6], kv[1] ^ kv[2] ^ kv[5]);
    end

    // Reset in mid run.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(o_st == 4'b0000, "R1 open re-reset stages", o_st, 0);
    check(o_cnt == 4'd0, "R1 open re-reset count", o_cnt, 0);
    check(r_st == 3'b100, "R1 ring re-reset stages", r_st, 3'b100);
    check(r_cnt == 4'd0, "R1 ring re-reset count", r_cnt, 0);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule